// File: doc/BRIEF.md
# Cache Tag Directory Store with Hit Compare

A synchronous directory memory for a cache. Every address holds a tag word and three status flags: valid, dirty and write-through. The caller picks one of four operations each cycle with two active-low controls, an output-enable and a write enable. The operations are a clocked write of tag and flags, a read of the stored tag onto a tag bus, a compare of an incoming tag against the stored one, and a clear. The clear acts at once, without the clock, and drops every status flag in the array.

The tag bus is split into an input, an output and a drive-enable, so it can sit behind a bidirectional pad elsewhere on the chip. Status outputs and the hit flag are combinational from the stored contents and the current inputs. A written value can therefore be seen from the cycle after its writing clock edge.

Top module: `cache_tag_store`

## Requirements
- R1: While `clr_n` is low, `vld_out`, `dty_out`, `wt_out` and `hit` are 0 and `tag_drive` is 0.
- R2: A low `clr_n` clears the valid, dirty and write-through flags of every entry without waiting for a clock edge. Stored tag words keep their contents.
- R3: A write request (`we_n`=0, `oe_n`=1) made while `clr_n` is low stores nothing. After release, that entry's flags read 0 and its tag is unchanged.
- R4: With `clr_n`=1, `we_n`=0 and `oe_n`=1, the rising clock edge stores `tag_in`, `vld_in`, `dty_in` and `wt_in` at `addr`. Reads and compares see them from the next cycle.
- R5: During a write, `tag_out` equals `tag_in`, `tag_drive` is 1, the three status outputs equal the status inputs, and `hit` is 0.
- R6: With `we_n`=0 and `oe_n`=0, nothing is stored, `tag_drive` is 0, `hit` is 0, and the status outputs show the stored flags.
- R7: A read (`oe_n`=0, `we_n`=1) sets `tag_drive` to 1, puts the stored tag on `tag_out`, shows the stored flags, and holds `hit` at 0.
- R8: A compare (`oe_n`=1, `we_n`=1) against an entry whose stored valid flag is 0 gives `hit`=0, even when the tags are equal.
- R9: A compare against a valid entry gives `hit`=1 exactly when `tag_in` equals the stored tag. The status outputs show the stored flags and `tag_drive` is 0.
- R10: Whenever `tag_drive` is 0, `tag_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| clr_n | input | 1 | Active-low asynchronous clear of all status flags |
| addr | input | ADDR_W | Entry select |
| oe_n | input | 1 | Active-low tag output-enable |
| we_n | input | 1 | Active-low write enable |
| tag_in | input | TAG_W | Tag to write or compare |
| tag_out | output | TAG_W | Tag bus output value |
| tag_drive | output | 1 | High when the block drives the tag bus |
| vld_in | input | 1 | Valid flag to write |
| dty_in | input | 1 | Dirty flag to write |
| wt_in | input | 1 | Write-through flag to write |
| vld_out | output | 1 | Valid flag output |
| dty_out | output | 1 | Dirty flag output |
| wt_out | output | 1 | Write-through flag output |
| hit | output | 1 | Compare result |

## Verification
The clear, write-through, read and compare results are combinational, so each is due in the same cycle as its stimulus. Stored data changes only on the writing edge, or at once on clear, and becomes visible in the following cycle. The bench drives inputs at the falling edge and samples outputs 1 ns later, before the next rising edge. It updates its reference arrays only after that sample, so every expectation reflects contents as of the preceding edge.

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 12
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [TAG_W-1:0]  tag_in,
  output logic [TAG_W-1:0]  tag_out,
  output logic              tag_drive,
  input  logic              vld_in,
  input  logic              dty_in,
  input  logic              wt_in,
  output logic              vld_out,
  output logic              dty_out,
  output logic              wt_out,
  output logic              hit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [DEPTH-1:0] vld_q, dty_q, wt_q;

  logic wr, rd, cmp;
  logic [TAG_W-1:0] tag_rd;

  assign wr  = clr_n & ~we_n &  oe_n;
  assign rd  = clr_n &  we_n & ~oe_n;
  assign cmp = clr_n &  we_n &  oe_n;

  always_ff @(posedge clk)
    if (wr) tag_mem[addr] <= tag_in;

  always_ff @(posedge clk or negedge clr_n)
    if (!clr_n) begin
      vld_q <= '0;
      dty_q <= '0;
      wt_q  <= '0;
    end else if (wr) begin
      vld_q[addr] <= vld_in;
      dty_q[addr] <= dty_in;
      wt_q[addr]  <= wt_in;
    end

  assign tag_rd    = tag_mem[addr];
  assign tag_drive = wr | rd;
  assign tag_out   = wr ? tag_in : (rd ? tag_rd : '0);

  assign vld_out = clr_n & (wr ? vld_in : vld_q[addr]);
  assign dty_out = clr_n & (wr ? dty_in : dty_q[addr]);
  assign wt_out  = clr_n & (wr ? wt_in  : wt_q[addr]);

  assign hit = cmp & vld_q[addr] & (tag_in == tag_rd);
endmodule

module cache_tag_store_chk #(
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 12
) (
  input logic              clk,
  input logic              clr_n,
  input logic [ADDR_W-1:0] addr,
  input logic              oe_n,
  input logic              we_n,
  input logic [TAG_W-1:0]  tag_in,
  input logic [TAG_W-1:0]  tag_out,
  input logic              tag_drive,
  input logic              vld_in,
  input logic              dty_in,
  input logic              wt_in,
  input logic              vld_out,
  input logic              dty_out,
  input logic              wt_out,
  input logic              hit
);
  always @(posedge clk)
    if (!clr_n)
      a_r1_clear_quiet: assert (!vld_out && !dty_out && !wt_out && !hit && !tag_drive);

  a_r4_write_lands: assert property (@(posedge clk) disable iff (!clr_n)
    (oe_n && !we_n) |=> ((oe_n && we_n && addr == $past(addr)) |->
      (vld_out == $past(vld_in) && dty_out == $past(dty_in) && wt_out == $past(wt_in))));

  a_r5_write_through: assert property (@(posedge clk) disable iff (!clr_n)
    (oe_n && !we_n) |-> (tag_drive && tag_out == tag_in && !hit &&
                         vld_out == vld_in && dty_out == dty_in && wt_out == wt_in));

  a_r6_illegal_no_drive: assert property (@(posedge clk) disable iff (!clr_n)
    (!oe_n && !we_n) |-> (!tag_drive && !hit));

  a_r7_read_no_hit: assert property (@(posedge clk) disable iff (!clr_n)
    (!oe_n && we_n) |-> (tag_drive && !hit));

  a_r8_invalid_miss: assert property (@(posedge clk) disable iff (!clr_n)
    (oe_n && we_n && !vld_out) |-> !hit);

  a_r9_hit_needs_equal: assert property (@(posedge clk) disable iff (!clr_n)
    hit |-> (oe_n && we_n && !tag_drive));
endmodule

bind cache_tag_store cache_tag_store_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) chk_i (
  .clk(clk), .clr_n(clr_n), .addr(addr), .oe_n(oe_n), .we_n(we_n),
  .tag_in(tag_in), .tag_out(tag_out), .tag_drive(tag_drive),
  .vld_in(vld_in), .dty_in(dty_in), .wt_in(wt_in),
  .vld_out(vld_out), .dty_out(dty_out), .wt_out(wt_out), .hit(hit)
);

// File: tb/cache_tag_store_tb.sv
`timescale 1ns/1ps
module cache_tag_store_tb_top;
  localparam int AW = 8;
  localparam int TW = 12;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          clr_n = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [TW-1:0] tag_in = '0;
  logic          vld_in = 0, dty_in = 0, wt_in = 0;
  logic [TW-1:0] tag_out;
  logic          tag_drive, vld_out, dty_out, wt_out, hit;

  cache_tag_store #(.ADDR_W(AW), .TAG_W(TW)) dut_i (
    .clk(clk), .clr_n(clr_n), .addr(addr), .oe_n(oe_n), .we_n(we_n),
    .tag_in(tag_in), .tag_out(tag_out), .tag_drive(tag_drive),
    .vld_in(vld_in), .dty_in(dty_in), .wt_in(wt_in),
    .vld_out(vld_out), .dty_out(dty_out), .wt_out(wt_out), .hit(hit));

  logic [TW-1:0] ref_tag [DEPTH];
  logic          ref_v [DEPTH];
  logic          ref_d [DEPTH];
  logic          ref_w [DEPTH];

  int checks = 0;
  int failures = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string mode_req(input bit c, input bit o, input bit w, input bit vs);
    if (!c) return "R1";
    if (!w && o) return "R5";
    if (!w && !o) return "R6";
    if (!o) return "R7";
    return vs ? "R9" : "R8";
  endfunction

  task automatic step(input bit c, input bit o, input bit w, input logic [AW-1:0] a,
                      input logic [TW-1:0] t, input bit v, input bit d, input bit wt,
                      input string lbl);
    logic [TW-1:0] e_tag;
    logic e_drv, e_v, e_d, e_w, e_hit;
    string req;
    @(negedge clk);
    clr_n = c; oe_n = o; we_n = w; addr = a; tag_in = t;
    vld_in = v; dty_in = d; wt_in = wt;
    #1;
    e_tag = '0; e_drv = 0; e_hit = 0;
    e_v = ref_v[a]; e_d = ref_d[a]; e_w = ref_w[a];
    if (!c) begin
      e_v = 0; e_d = 0; e_w = 0;
    end else if (!w && o) begin
      e_drv = 1; e_tag = t; e_v = v; e_d = d; e_w = wt;
    end else if (!w && !o) begin
      e_drv = 0;
    end else if (!o) begin
      e_drv = 1; e_tag = ref_tag[a];
    end else begin
      e_hit = ref_v[a] && (t == ref_tag[a]);
    end
    req = (lbl != "") ? lbl : mode_req(c, o, w, ref_v[a]);
    chk(req, "tag_drive", 32'(tag_drive), 32'(e_drv));
    chk((e_drv ? req : "R10"), "tag_out", 32'(tag_out), 32'(e_tag));
    chk(req, "vld_out", 32'(vld_out), 32'(e_v));
    chk(req, "dty_out", 32'(dty_out), 32'(e_d));
    chk(req, "wt_out", 32'(wt_out), 32'(e_w));
    chk(req, "hit", 32'(hit), 32'(e_hit));
    if (!c) begin
      for (int i = 0; i < DEPTH; i++) begin
        ref_v[i] = 0; ref_d[i] = 0; ref_w[i] = 0;
      end
    end else if (!w && o) begin
      ref_tag[a] = t; ref_v[a] = v; ref_d[a] = d; ref_w[a] = wt;
    end
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    for (int i = 0; i < DEPTH; i++) begin
      ref_tag[i] = '0; ref_v[i] = 0; ref_d[i] = 0; ref_w[i] = 0;
    end
    // R1: reset state
    step(0, 1, 1, 8'h00, 12'h000, 0, 0, 0, "R1");
    step(0, 0, 1, 8'h05, 12'h000, 0, 0, 0, "R1");
    // R4: fill every entry
    for (int i = 0; i < DEPTH; i++)
      step(1, 1, 0, AW'(i), TW'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R4");
    // R4 / R7: read back
    for (int i = 0; i < DEPTH; i += 17)
      step(1, 0, 1, AW'(i), '0, 0, 0, 0, "R7");
    // R9: directed hit and miss
    step(1, 1, 0, 8'h10, 12'hABC, 1, 1, 0, "R5");
    step(1, 1, 1, 8'h10, 12'hABC, 0, 0, 0, "R9");
    step(1, 1, 1, 8'h10, 12'hABD, 0, 0, 0, "R9");
    // R8: equal tag, invalid entry
    step(1, 1, 0, 8'h11, 12'h777, 0, 1, 1, "R5");
    step(1, 1, 1, 8'h11, 12'h777, 0, 0, 0, "R8");
    // R6: illegal combination stores nothing
    step(1, 0, 0, 8'h10, 12'h123, 0, 0, 1, "R6");
    step(1, 0, 1, 8'h10, 12'h000, 0, 0, 0, "R6");
    step(1, 1, 1, 8'h10, 12'hABC, 0, 0, 0, "R6");
    // R2 / R3: clear with write request, then check all entries
    step(0, 1, 0, 8'h10, 12'h555, 1, 1, 1, "R3");
    step(1, 0, 1, 8'h10, 12'h000, 0, 0, 0, "R3");
    step(1, 1, 1, 8'h10, 12'hABC, 0, 0, 0, "R3");
    for (int i = 0; i < DEPTH; i++)
      step(1, 1, 1, AW'(i), ref_tag[i], 0, 0, 0, "R2");
    for (int i = 3; i < DEPTH; i += 31)
      step(1, 0, 1, AW'(i), '0, 0, 0, 0, "R2");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int unsigned r = $urandom % 64;
      logic [AW-1:0] a = AW'($urandom % 16);
      logic [TW-1:0] t = ($urandom % 2) ? ref_tag[a] : TW'($urandom);
      if (r == 0)      step(0, 1'($urandom), 1'($urandom), a, t, 1, 1, 1, "");
      else if (r < 20) step(1, 1, 0, a, t, 1'($urandom % 4 != 0), 1'($urandom), 1'($urandom), "");
      else if (r < 24) step(1, 0, 0, a, t, 1, 1, 1, "");
      else if (r < 36) step(1, 0, 1, a, t, 0, 0, 0, "");
      else             step(1, 1, 1, a, t, 0, 0, 0, "");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule